// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block carries out the memory side of exception entry and exception return for a 68k-style processor core. It talks to memory through a 16-bit word port. On an entry request it takes the vector number, a hardware-interrupt flag, the pending interrupt level, the requested frame format and the current PC, SR and stack pointers. It works out the new status register and writes the exception frame below the aligned stack pointer. It then reads the handler address from the vector table and pulses `done` with the new PC, SR and stack pointer on its outputs.

A hardware interrupt taken while the master-stack bit is set produces two frames. A normal frame goes on the current stack and a throwaway frame goes on the interrupt stack, and the master bit is cleared in the final SR. On a return request the block reads SR, PC and the format word from the stack. It moves the stack pointer past any extra words that format carries. A throwaway frame makes it start the whole return again on the next frame up.

Memory reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. Longwords are stored as two words, with the high half at the lower address.

Top module: `exc_frame_seq`

## Requirements
- R1: With `hw_irq` high, an entry request is accepted only when SR bits 10:8 (interrupt mask) are strictly less than `irq_level`. A refused request makes no memory access and no `done` pulse.
- R2: The frame holds the old SR. The new SR is the old SR with bit 13 (supervisor) set and bit 15 (trace) cleared. For a hardware interrupt, bits 10:8 are also loaded with `irq_level`.
- R3: Bit 0 of the stack pointer is cleared before the frame is placed, so every frame write goes to an even address.
- R4: For a frame based at address B, the words are laid out as follows: the old SR at B, the return PC at B+2 (high half) and B+4 (low half), and at B+6 the word (format << 12) | (vector << 2).
- R5: Format 2 adds the `aux_addr` longword at B+8. Format 4 adds `aux_addr` at B+8 and the current PC at B+12. A software request for any format other than 2 or 4, and every hardware interrupt, gives format 0 with no extra words. The number of words written is 4, 6 or 8 to match.
- R6: For a software request with a vector from 32 to 47 inclusive, the saved return PC is `cur_pc` + 2. For every other request it is `cur_pc`.
- R7: After the frame, `pc_out` is the longword read at `vbr` + 4 × vector. `done` is high for exactly one cycle, and `sp_out` equals the frame base.
- R8: A hardware interrupt with SR bit 12 (master) set produces two frames. The first is a format 0 frame holding the old SR, based 8 below the aligned `cur_sp`; `msp_out` reports its base. The second is a format 1 frame holding the new SR with bit 12 still set, based 8 below the aligned `int_sp`; `sp_out` reports its base. The final SR has bit 12 cleared. Without this case, `msp_out` equals `sp_out`.
- R9: On return, the block reads SR at `cur_sp`, PC at +2/+4 and the format word at +6. The final `sp_out` is `cur_sp` + 8 plus a skip set by format bits 15:12: 4 for formats 2 and 3, 8 for format 4, 52 for format 7, and 0 for any other format.
- R10: A return that meets format 1 starts over with the frame at the current address + 8. The reported SR, PC and stack pointer come from the first frame that is not format 1.
- R11: Entry and return requests that arrive while `busy` is high are ignored.
- R12: A return makes no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Start exception entry (takes priority over return) |
| return_req | input | 1 | Start exception return |
| vec_num | input | 8 | Exception vector number |
| hw_irq | input | 1 | Entry is a hardware interrupt |
| irq_level | input | 3 | Pending interrupt level |
| req_fmt | input | 4 | Frame format requested for a software exception |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status register |
| cur_sp | input | 32 | Active supervisor stack pointer |
| int_sp | input | 32 | Interrupt stack pointer used by the master-bit case |
| aux_addr | input | 32 | Address longword for formats 2 and 4 |
| vbr | input | 32 | Vector base address |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data for `mem_addr`, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 32 | New program counter |
| sr_out | output | 16 | New status register |
| sp_out | output | 32 | New active stack pointer |
| msp_out | output | 32 | Master stack pointer after an entry |

## Verification
The interrupt path is swept over every mask and level pair. This separates acceptance from refusal at the equal-value boundary and checks the loaded mask and the trace clear. Software entries cover formats 0, 2, 4 and several unsupported codes, with vectors on both sides of the trap range, odd and even stack pointers, and two vector bases. These patterns separate frame size, return-PC adjustment, alignment and table addressing. Master-bit interrupts check the two frames and the two stack results. Return frames are built for all sixteen format codes, and a throwaway frame is followed by formats 0, 4 and 7, to separate the skip distances from the restart walk.

// File: rtl/exc_frame_seq.sv
`timescale 1ns/1ps
module exc_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        entry_req,
  input  logic        return_req,
  input  logic [7:0]  vec_num,
  input  logic        hw_irq,
  input  logic [2:0]  irq_level,
  input  logic [3:0]  req_fmt,
  input  logic [31:0] cur_pc,
  input  logic [15:0] cur_sr,
  input  logic [31:0] cur_sp,
  input  logic [31:0] int_sp,
  input  logic [31:0] aux_addr,
  input  logic [31:0] vbr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] pc_out,
  output logic [15:0] sr_out,
  output logic [31:0] sp_out,
  output logic [31:0] msp_out
);

  localparam int TRACE_BIT = 15;
  localparam int SUPV_BIT  = 13;
  localparam int MSTR_BIT  = 12;

  typedef enum logic [2:0] {IDLE, PUSH, VHI, VLO, POP} st_t;

  st_t         st;
  logic [2:0]  cnt;
  logic [3:0]  fmt_q;
  logic [7:0]  vec_q;
  logic [31:0] base_q, ret_q, pc_q, aux_q, vbr_q, isp_q;
  logic [15:0] frame_sr_q, new_sr_q, pc_hi_q;
  logic        nest_q, is_ret_q;

  // entry decode
  logic        accept, master, trap;
  logic [15:0] ent_sr;
  logic [3:0]  ent_fmt;
  logic [2:0]  ent_last;
  logic [4:0]  ent_bytes;
  logic [31:0] ent_base;

  assign accept = !hw_irq || (cur_sr[10:8] < irq_level);
  assign master = hw_irq && cur_sr[MSTR_BIT];
  assign trap   = !hw_irq && (vec_num[7:4] == 4'h2);

  always_comb begin
    ent_sr = cur_sr;
    ent_sr[SUPV_BIT]  = 1'b1;
    ent_sr[TRACE_BIT] = 1'b0;
    if (hw_irq) ent_sr[10:8] = irq_level;
  end

  assign ent_fmt   = (!hw_irq && (req_fmt == 4'd2 || req_fmt == 4'd4)) ? req_fmt : 4'd0;
  assign ent_last  = (ent_fmt == 4'd4) ? 3'd7 : (ent_fmt == 4'd2) ? 3'd5 : 3'd3;
  assign ent_bytes = {1'b0, ent_last, 1'b0} + 5'd2;
  assign ent_base  = (cur_sp & ~32'd1) - {27'd0, ent_bytes};

  function automatic logic [31:0] frame_skip(input logic [3:0] f);
    case (f)
      4'd2, 4'd3: return 32'd4;
      4'd4:       return 32'd8;
      4'd7:       return 32'd52;
      default:    return 32'd0;
    endcase
  endfunction

  // word at offset 2*cnt from the frame base
  logic [15:0] slot_word;
  always_comb begin
    case (cnt)
      3'd0:    slot_word = frame_sr_q;
      3'd1:    slot_word = ret_q[31:16];
      3'd2:    slot_word = ret_q[15:0];
      3'd3:    slot_word = {fmt_q, 2'b00, vec_q, 2'b00};
      3'd4:    slot_word = aux_q[31:16];
      3'd5:    slot_word = aux_q[15:0];
      3'd6:    slot_word = pc_q[31:16];
      default: slot_word = pc_q[15:0];
    endcase
  end

  logic [31:0] slot_addr, vec_addr;
  assign slot_addr = base_q + {28'd0, cnt, 1'b0};
  assign vec_addr  = vbr_q + {22'd0, vec_q, 2'b00};

  assign busy      = (st != IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == PUSH);
  assign mem_wdata = slot_word;
  assign mem_addr  = (st == VHI) ? vec_addr :
                     (st == VLO) ? vec_addr + 32'd2 : slot_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;        cnt <= 3'd0;       fmt_q <= 4'd0;    vec_q <= 8'd0;
      base_q <= 32'd0;   ret_q <= 32'd0;    pc_q <= 32'd0;    aux_q <= 32'd0;
      vbr_q <= 32'd0;    isp_q <= 32'd0;    frame_sr_q <= 16'd0;
      new_sr_q <= 16'd0; pc_hi_q <= 16'd0;  nest_q <= 1'b0;   is_ret_q <= 1'b0;
      done <= 1'b0;      pc_out <= 32'd0;   sr_out <= 16'd0;
      sp_out <= 32'd0;   msp_out <= 32'd0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (entry_req && accept) begin
            st         <= PUSH;
            cnt        <= ent_last;
            fmt_q      <= ent_fmt;
            vec_q      <= vec_num;
            base_q     <= ent_base;
            ret_q      <= trap ? cur_pc + 32'd2 : cur_pc;
            pc_q       <= cur_pc;
            aux_q      <= aux_addr;
            vbr_q      <= vbr;
            isp_q      <= int_sp;
            frame_sr_q <= cur_sr;
            new_sr_q   <= ent_sr;
            nest_q     <= master;
            is_ret_q   <= 1'b0;
          end else if (return_req && !entry_req) begin
            st       <= POP;
            cnt      <= 3'd0;
            base_q   <= cur_sp;
            is_ret_q <= 1'b1;
          end
        end
        PUSH: begin
          if (cnt != 3'd0) begin
            cnt <= cnt - 3'd1;
          end else if (nest_q) begin
            nest_q             <= 1'b0;
            msp_out            <= base_q;
            fmt_q              <= 4'd1;
            frame_sr_q         <= new_sr_q;
            new_sr_q[MSTR_BIT] <= 1'b0;
            base_q             <= (isp_q & ~32'd1) - 32'd8;
            cnt                <= 3'd3;
          end else begin
            sp_out <= base_q;
            if (fmt_q != 4'd1) msp_out <= base_q;
            st <= VHI;
          end
        end
        VHI: begin
          pc_hi_q <= mem_rdata;
          st      <= VLO;
        end
        VLO: begin
          pc_out <= {pc_hi_q, mem_rdata};
          sr_out <= new_sr_q;
          done   <= 1'b1;
          st     <= IDLE;
        end
        POP: begin
          cnt <= (cnt == 3'd3) ? 3'd0 : cnt + 3'd1;
          case (cnt)
            3'd0: frame_sr_q <= mem_rdata;
            3'd1: pc_hi_q    <= mem_rdata;
            3'd2: ret_q      <= {pc_hi_q, mem_rdata};
            default: begin
              sr_out <= frame_sr_q;
              if (mem_rdata[15:12] == 4'd1) begin
                base_q <= base_q + 32'd8;
              end else begin
                sp_out <= base_q + 32'd8 + frame_skip(mem_rdata[15:12]);
                pc_out <= ret_q;
                done   <= 1'b1;
                st     <= IDLE;
              end
            end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && entry_req && hw_irq && (cur_sr[10:8] >= irq_level)) |=> !busy);

  assert_new_sr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_ret_q) |-> (sr_out[SUPV_BIT] && !sr_out[TRACE_BIT]));

  assert_even_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_addr[0]);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_master_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_ret_q && (sp_out != msp_out)) |-> !sr_out[MSTR_BIT]);

  assert_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_ret_q) |-> !mem_we);

endmodule

// File: tb/exc_frame_seq_bench.sv
`timescale 1ns/1ps
module exc_frame_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, return_req = 1'b0, hw_irq = 1'b0;
  logic [7:0]  vec_num = '0;
  logic [2:0]  irq_level = '0;
  logic [3:0]  req_fmt = '0;
  logic [31:0] cur_pc = '0, cur_sp = '0, int_sp = '0, aux_addr = '0, vbr = '0;
  logic [15:0] cur_sr = '0;
  logic        mem_req, mem_we, busy, done;
  logic [31:0] mem_addr, pc_out, sp_out, msp_out;
  logic [15:0] mem_wdata, mem_rdata, sr_out;

  logic [15:0] mem [0:4095];
  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0;
  logic [15:0] tb_data = '0;
  int unsigned nwr = 0, ndone = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  exc_frame_seq u_exc_frame_seq (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
    .vec_num(vec_num), .hw_irq(hw_irq), .irq_level(irq_level), .req_fmt(req_fmt),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp), .int_sp(int_sp),
    .aux_addr(aux_addr), .vbr(vbr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pc_out(pc_out), .sr_out(sr_out),
    .sp_out(sp_out), .msp_out(msp_out));

  assign mem_rdata = mem[mem_addr[12:1]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[12:1]] <= tb_data;
    else if (mem_req && mem_we) mem[mem_addr[12:1]] <= mem_wdata;
    if (mem_req && mem_we) nwr <= nwr + 1;
    if (done) ndone <= ndone + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return mem[a[12:1]];
  endfunction

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[a[12:1]], mem[a[12:1] + 12'd1]};
  endfunction

  function automatic logic [31:0] handler(input logic [31:0] vb, input logic [7:0] v);
    return (vb == 32'd0) ? {8'hC0, v, v, ~v} : {8'hD0, v, ~v, v};
  endfunction

  function automatic logic [31:0] skip_of(input logic [3:0] f);
    if (f == 4'd2 || f == 4'd3) return 32'd4;
    if (f == 4'd4) return 32'd8;
    if (f == 4'd7) return 32'd52;
    return 32'd0;
  endfunction

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 80 && !got; i++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_entry(input logic [7:0] v, input bit hw, input logic [2:0] lvl,
                           input logic [3:0] f, input logic [31:0] pc, input logic [15:0] sr,
                           input logic [31:0] sp, input logic [31:0] isp,
                           input logic [31:0] vb, input bit hold);
    int unsigned w0, d0, nw;
    logic [31:0] aux, ret, b0, b1;
    logic [15:0] nsr;
    logic [3:0]  ef;
    bit acc, mst, got;
    aux = {8'h5A, v, pc[15:0] ^ 16'h1234};
    w0 = nwr; d0 = ndone;
    @(negedge clk);
    vec_num = v; hw_irq = hw; irq_level = lvl; req_fmt = f; cur_pc = pc;
    cur_sr = sr; cur_sp = sp; int_sp = isp; aux_addr = aux; vbr = vb;
    entry_req = 1'b1;
    @(negedge clk); entry_req = 1'b0;
    acc = !hw || (sr[10:8] < lvl);
    if (hold) begin
      entry_req = 1'b1; return_req = 1'b1; vec_num = v + 8'd1; cur_sp = sp - 32'd64;
      repeat (3) @(negedge clk);
      entry_req = 1'b0; return_req = 1'b0;
    end
    if (!acc) begin
      repeat (12) @(negedge clk);
      check("R1 refused irq writes", nwr - w0, 0);
      check("R1 refused irq done", ndone - d0, 0);
    end else begin
      ef  = (!hw && (f == 4'd2 || f == 4'd4)) ? f : 4'd0;
      nw  = (ef == 4'd4) ? 8 : (ef == 4'd2) ? 6 : 4;
      mst = hw && sr[12];
      nsr = (sr | 16'h2000) & 16'h7FFF;
      if (hw) nsr = (nsr & 16'hF8FF) | {5'd0, lvl, 8'd0};
      ret = (!hw && v >= 8'd32 && v <= 8'd47) ? pc + 32'd2 : pc;
      b0  = (sp & ~32'd1) - 32'(2 * nw);
      b1  = (isp & ~32'd1) - 32'd8;
      wait_done(got);
      check("R7 done seen", {31'd0, got}, 32'd1);
      @(negedge clk);
      check("R7 done single cycle", {31'd0, done}, 32'd0);
      check("R7 handler pc", pc_out, handler(vb, v));
      check("R2 frame old sr", {16'd0, rd16(b0)}, {16'd0, sr});
      check("R6 return pc", rd32(b0 + 32'd2), ret);
      check("R4 format word", {16'd0, rd16(b0 + 32'd6)}, {16'd0, ef, 2'b00, v, 2'b00});
      if (ef == 4'd2 || ef == 4'd4) check("R5 aux longword", rd32(b0 + 32'd8), aux);
      if (ef == 4'd4) check("R5 pc longword", rd32(b0 + 32'd12), pc);
      if (mst) begin
        check("R8 write count", nwr - w0, 8);
        check("R8 msp_out", msp_out, b0);
        check("R8 sp_out", sp_out, b1);
        check("R8 throwaway sr", {16'd0, rd16(b1)}, {16'd0, nsr});
        check("R8 throwaway fmt", {16'd0, rd16(b1 + 32'd6)}, {16'd0, 4'd1, 2'b00, v, 2'b00});
        check("R8 throwaway pc", rd32(b1 + 32'd2), ret);
        check("R8 final sr", {16'd0, sr_out}, {16'd0, nsr & 16'hEFFF});
      end else begin
        check(hold ? "R11 write count while busy" : "R5 write count", nwr - w0, nw);
        check("R3 sp_out aligned base", sp_out, b0);
        check("R8 msp_out equals sp_out", msp_out, b0);
        check("R2 new sr", {16'd0, sr_out}, {16'd0, nsr});
      end
      if (hold) check("R11 only one completion", ndone - d0, 1);
    end
  endtask

  task automatic run_return(input logic [31:0] sp, input logic [3:0] fa, input logic [15:0] sra,
                            input logic [31:0] pca, input logic [3:0] fb, input logic [15:0] srb,
                            input logic [31:0] pcb);
    int unsigned w0;
    bit got;
    poke(sp, sra); poke(sp + 32'd2, pca[31:16]); poke(sp + 32'd4, pca[15:0]);
    poke(sp + 32'd6, {fa, 12'h0A8});
    if (fa == 4'd1) begin
      poke(sp + 32'd8, srb); poke(sp + 32'd10, pcb[31:16]); poke(sp + 32'd12, pcb[15:0]);
      poke(sp + 32'd14, {fb, 12'h074});
    end
    w0 = nwr;
    @(negedge clk); cur_sp = sp; return_req = 1'b1;
    @(negedge clk); return_req = 1'b0;
    wait_done(got);
    check("R9 return done", {31'd0, got}, 32'd1);
    if (fa == 4'd1) begin
      check("R10 pc from next frame", pc_out, pcb);
      check("R10 sr from next frame", {16'd0, sr_out}, {16'd0, srb});
      check("R10 sp after walk", sp_out, sp + 32'd16 + skip_of(fb));
    end else begin
      check("R9 pc", pc_out, pca);
      check("R9 sr", {16'd0, sr_out}, {16'd0, sra});
      check("R9 sp skip", sp_out, sp + 32'd8 + skip_of(fa));
    end
    @(negedge clk);
    check("R12 no writes on return", nwr - w0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset busy", {31'd0, busy}, 0);
    check("reset done", {31'd0, done}, 0);
    check("reset mem_req", {31'd0, mem_req}, 0);
    check("reset pc_out", pc_out, 0);
    rst_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      poke(32'(v * 4), {8'hC0, 8'(v)});
      poke(32'(v * 4 + 2), {8'(v), ~8'(v)});
      poke(32'h400 + 32'(v * 4), {8'hD0, 8'(v)});
      poke(32'h402 + 32'(v * 4), {~8'(v), 8'(v)});
    end
    // R1/R2: interrupt mask against level, every pair
    for (int lv = 1; lv < 8; lv++)
      for (int mk = 0; mk < 8; mk++)
        run_entry(8'(24 + lv), 1'b1, 3'(lv), 4'd2, 32'h0001_0000 + 32'(lv * 16 + mk),
                  16'h2000 | {5'd0, 3'(mk), 8'h1F} | ((mk % 2 == 1) ? 16'h8000 : 16'h0),
                  32'h1F00 + 32'(mk % 2), 32'h1800, 32'd0, 1'b0);
    // R3-R7: software formats and trap boundaries
    for (int fi = 0; fi < 6; fi++)
      for (int vi = 0; vi < 5; vi++) begin
        logic [3:0] ff;
        logic [7:0] vv;
        ff = (fi == 0) ? 4'd0 : (fi == 1) ? 4'd2 : (fi == 2) ? 4'd4 :
             (fi == 3) ? 4'd3 : (fi == 4) ? 4'd7 : 4'd15;
        vv = (vi == 0) ? 8'd4 : (vi == 1) ? 8'd32 : (vi == 2) ? 8'd47 :
             (vi == 3) ? 8'd48 : 8'd31;
        run_entry(vv, 1'b0, 3'd0, ff, 32'h00AB_0000 + 32'(fi * 64 + vi * 2),
                  (vi % 2 == 0) ? 16'h0004 : 16'h8711, 32'h1E00 + 32'(vi % 2) + 32'(fi * 32),
                  32'h1800, (fi % 2 == 0) ? 32'd0 : 32'h400, 1'b0);
      end
    // R8: master bit set
    run_entry(8'd29, 1'b1, 3'd5, 4'd0, 32'h0040_1230, 16'h3204, 32'h1F41, 32'h1701, 32'd0, 1'b0);
    run_entry(8'd30, 1'b1, 3'd6, 4'd4, 32'h0040_4560, 16'hB015, 32'h1E80, 32'h1600, 32'h400, 1'b0);
    run_entry(8'd31, 1'b1, 3'd7, 4'd0, 32'h0040_7890, 16'h3600, 32'h1E21, 32'h1681, 32'd0, 1'b0);
    // R11: requests while busy
    run_entry(8'd36, 1'b0, 3'd0, 4'd4, 32'h0050_0000, 16'h0000, 32'h1D00, 32'h1800, 32'd0, 1'b1);
    // R9/R12: all format codes on return
    for (int f = 0; f < 16; f++)
      if (f != 1)
        run_return(32'h1400 + 32'(f * 8), 4'(f), 16'h2700 ^ 16'(f), 32'h0070_0000 + 32'(f * 4),
                   4'd0, 16'h0, 32'h0);
    // R10: throwaway frame followed by several formats
    run_return(32'h1300, 4'd1, 16'h3700, 32'h0080_0000, 4'd0, 16'h2300, 32'h0081_0000);
    run_return(32'h1300, 4'd1, 16'h3500, 32'h0082_0000, 4'd4, 16'h2100, 32'h0083_0000);
    run_return(32'h1300, 4'd1, 16'h3400, 32'h0084_0000, 4'd7, 16'h0008, 32'h0085_0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule